// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a virtual address into a physical address after the translation buffer has missed. The requester presents the 32-bit virtual address and a flag that names the security world (0 = secure, 1 = non-secure) while `miss_ready` is high. The walker then reads that world's bank of control registers and picks one of two table bases. If walks are disabled for the chosen base, it reports a section translation fault at once and does not touch memory. Otherwise it reads a first-level descriptor over a single-request read port. That descriptor either maps a 1 MB section or points to a coarse second-level table. In the second case the walker reads one more descriptor, which maps a 64 KB large page or a 4 KB small page.

Each world holds its own control register and its own two base registers. Software writes them through a small write port. The control register carries a split field `split` (bits [2:0]) and two disable bits, `off0` (bit 4, for base 0) and `off1` (bit 5, for base 1). The result of every walk comes out with a single-cycle `done` pulse that carries the physical address, the page size and a fault code.

Top module: `ptw_top`

## Requirements
- R1: After reset, `miss_ready` is 1, `done` and `mem_req` are 0, and all six configuration registers read as zero. With these zeros, a walk in either world uses base 0 at address 0.
- R2: A write with `cfg_we` high goes to the bank named by `cfg_ns`. `cfg_sel` selects the register: 0 = control, 1 = base 0, 2 = base 1, 3 = no register. A write changes nothing in the other world's bank.
- R3: Let n be the split value. Base 1 is chosen exactly when n is not 0 and at least one of virtual-address bits [31:32-n] is 1. Otherwise base 0 is chosen.
- R4: With base 0, the first-level address is base0 with its low 14-n bits cleared, OR'd with virtual-address bits [31-n:20] shifted left by 2. With base 1, it is base1[31:14] followed by va[31:20] and two zero bits.
- R5: If the chosen base's disable bit is set, no memory request is made. `done` is high in the cycle after the miss is accepted, with fault = 1 (section translation fault) and size = 0.
- R6: A first-level descriptor with bits [1:0] = 10 ends the walk after one read. It gives size = 1 (1 MB section) and pa = {desc[31:20], va[19:0]}.
- R7: A first-level descriptor with bits [1:0] = 00 or 11 ends the walk after one read, with fault = 1 and size = 0.
- R8: A first-level descriptor with bits [1:0] = 01 causes a second read at {desc[31:10], va[19:12], 00}.
- R9: A second-level descriptor with bits [1:0] = 00 ends the walk with fault = 2 (page translation fault) and size = 0.
- R10: A second-level descriptor with bits [1:0] = 01 gives size = 2 and pa = {desc[31:16], va[15:0]}. A value of 1x gives size = 3 and pa = {desc[31:12], va[11:0]}. In both cases fault = 0.
- R11: `miss_ready` is low while a walk is in progress, and a miss offered during that time is ignored. `mem_req` and `mem_addr` are held steady until `mem_ack`. `done` lasts one cycle per walk.
- R12: A configuration write in the same cycle that a miss is accepted does not affect that walk. The write takes effect from the next miss onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ns | input | 1 | World bank to write (0 secure, 1 non-secure) |
| cfg_sel | input | 2 | Register select: 0 control, 1 base 0, 2 base 1 |
| cfg_wdata | input | 32 | Write data |
| miss_valid | input | 1 | Translation miss offered |
| miss_ns | input | 1 | World of the missing access |
| miss_va | input | 32 | Virtual address of the missing access |
| miss_ready | output | 1 | Walker idle and able to accept a miss |
| mem_req | output | 1 | Descriptor read request, held until acknowledged |
| mem_addr | output | 32 | Descriptor address |
| mem_ack | input | 1 | Read data valid, ends the request |
| mem_rdata | input | 32 | Descriptor read data |
| done | output | 1 | One-cycle result pulse |
| pa | output | 32 | Physical address (zero on fault) |
| pg_size | output | 2 | 0 none, 1 section, 2 large page, 3 small page |
| fault | output | 2 | 0 none, 1 section translation fault, 2 page translation fault |

## Verification
A configuration write and the acceptance of a miss can fall in the same clock edge. The bench provokes this by writing the walked world's control register, with both disable bits set, in the same cycle that it presents the miss. It judges the result by checking that the walk still follows the old settings, with its memory reads and its result unchanged. The next miss in that world must then fault with no memory access. A second collision, a fresh miss offered while a walk is busy, is driven on many random walks. It is judged by checking that the result and the read addresses belong only to the first miss.

// File: rtl/ptw_pkg.sv
// Package: shared types and constants for the page table walker.
// Assumes a 32-bit virtual and physical address space and two security worlds.
package ptw_pkg;
    localparam int ADDR_W     = 32;
    localparam int SPLIT_W    = 3;
    localparam int NUM_WORLDS = 2;
    localparam int SEL_W      = 2;

    // Register select codes of the configuration write port
    localparam logic [SEL_W-1:0] SEL_CTL   = 2'd0;
    localparam logic [SEL_W-1:0] SEL_BASE0 = 2'd1;
    localparam logic [SEL_W-1:0] SEL_BASE1 = 2'd2;

    // Bit positions inside the control register write data
    localparam int CTL_OFF0_BIT = 4;
    localparam int CTL_OFF1_BIT = 5;

    typedef struct packed {
        logic               off1;
        logic               off0;
        logic [SPLIT_W-1:0] split;
    } ctl_t;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_SECT = 2'd1,
        FLT_PAGE = 2'd2
    } fault_e;

    typedef enum logic [1:0] {
        SZ_NONE  = 2'd0,
        SZ_SECT  = 2'd1,
        SZ_LARGE = 2'd2,
        SZ_SMALL = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        L1K_FAULT,
        L1K_COARSE,
        L1K_SECT
    } l1_kind_e;

    typedef enum logic [1:0] {
        L2K_FAULT,
        L2K_LARGE,
        L2K_SMALL
    } l2_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_L1,
        ST_L2
    } state_e;
endpackage

// File: rtl/ptw_regs.sv
// Module: banked translation control and base registers, one bank per world.
// Assumes a single write port and one combinational read port indexed by world.
module ptw_regs
    import ptw_pkg::*;
#(
    parameter int WORLDS = NUM_WORLDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_world,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              rd_world,
    output ctl_t              rd_ctl,
    output logic [ADDR_W-1:0] rd_base0,
    output logic [ADDR_W-1:0] rd_base1
);
    ctl_t              ctl_q   [WORLDS];
    logic [ADDR_W-1:0] base0_q [WORLDS];
    logic [ADDR_W-1:0] base1_q [WORLDS];

    for (genvar w = 0; w < WORLDS; w++) begin : g_bank
        // Update one world's registers on a write addressed to it
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctl_q[w]   <= '0;
                base0_q[w] <= '0;
                base1_q[w] <= '0;
            end else if (wr_en && (wr_world == 1'(w))) begin
                case (wr_sel)
                    SEL_CTL: ctl_q[w] <= '{off1:  wr_data[CTL_OFF1_BIT],
                                           off0:  wr_data[CTL_OFF0_BIT],
                                           split: wr_data[SPLIT_W-1:0]};
                    SEL_BASE0: base0_q[w] <= wr_data;
                    SEL_BASE1: base1_q[w] <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    // Present the bank of the requesting world
    always_comb begin
        rd_ctl   = ctl_q[rd_world];
        rd_base0 = base0_q[rd_world];
        rd_base1 = base1_q[rd_world];
    end
endmodule

// File: rtl/ptw_base_sel.sv
// Module: picks the table base, applies the walk-disable bits and forms the
// first-level descriptor address. Assumes the split value is at most 7.
module ptw_base_sel
    import ptw_pkg::*;
(
    input  ctl_t              ctl,
    input  logic [ADDR_W-1:0] base0,
    input  logic [ADDR_W-1:0] base1,
    input  logic [11:0]       va_top,
    output logic              use_b1,
    output logic              blocked,
    output logic [ADDR_W-1:0] l1_addr
);
    localparam int ALIGN_FULL = 14;

    logic [11:0]       top_mask;
    logic [11:0]       idx_mask;
    logic [4:0]        align;
    logic [ADDR_W-1:0] tbl_mask;

    // Base choice, table alignment and descriptor address
    always_comb begin
        top_mask = ~(12'hFFF >> ctl.split);
        use_b1   = (va_top & top_mask) != 12'd0;
        idx_mask = 12'hFFF >> ctl.split;
        align    = 5'(ALIGN_FULL) - {2'b00, ctl.split};
        tbl_mask = {ADDR_W{1'b1}} << align;
        if (use_b1)
            l1_addr = (base1 & ({ADDR_W{1'b1}} << ALIGN_FULL))
                    | {18'd0, va_top, 2'b00};
        else
            l1_addr = (base0 & tbl_mask) | {18'd0, va_top & idx_mask, 2'b00};
        blocked = use_b1 ? ctl.off1 : ctl.off0;
    end
endmodule

// File: rtl/ptw_desc_dec.sv
// Module: decodes first- and second-level descriptors and forms the
// second-level address and the physical address of each mapping size.
module ptw_desc_dec
    import ptw_pkg::*;
(
    input  logic [ADDR_W-1:0] desc,
    input  logic [19:0]       va_low,
    output l1_kind_e          l1_kind,
    output l2_kind_e          l2_kind,
    output logic [ADDR_W-1:0] l2_addr,
    output logic [ADDR_W-1:0] sect_pa,
    output logic [ADDR_W-1:0] large_pa,
    output logic [ADDR_W-1:0] small_pa
);
    // Classify the descriptor type at each level
    always_comb begin
        case (desc[1:0])
            2'b01:   l1_kind = L1K_COARSE;
            2'b10:   l1_kind = L1K_SECT;
            default: l1_kind = L1K_FAULT;
        endcase
        case (desc[1:0])
            2'b00:   l2_kind = L2K_FAULT;
            2'b01:   l2_kind = L2K_LARGE;
            default: l2_kind = L2K_SMALL;
        endcase
    end

    // Address forms for each mapping granularity
    always_comb begin
        l2_addr  = (desc & 32'hFFFF_FC00) | {22'd0, va_low[19:12], 2'b00};
        sect_pa  = {desc[31:20], va_low};
        large_pa = {desc[31:16], va_low[15:0]};
        small_pa = {desc[31:12], va_low[11:0]};
    end
endmodule

// File: rtl/ptw_top.sv
// Module: two-level page table walker. It accepts one miss at a time, reads
// descriptors over a held request / acknowledge port and reports the result
// with a one-cycle done pulse. Assumes mem_ack is only asserted with mem_req.
module ptw_top
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_ns,
    input  logic [1:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic              miss_valid,
    input  logic              miss_ns,
    input  logic [31:0]       miss_va,
    output logic              miss_ready,
    output logic              mem_req,
    output logic [31:0]       mem_addr,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              done,
    output logic [31:0]       pa,
    output logic [1:0]        pg_size,
    output logic [1:0]        fault
);
    state_e            state_q;
    logic [19:0]       va_low_q;
    logic [ADDR_W-1:0] addr_q;
    ctl_t              ctl;
    logic [ADDR_W-1:0] base0, base1, l1_addr;
    logic              use_b1, blocked, accept;
    l1_kind_e          l1_kind;
    l2_kind_e          l2_kind;
    logic [ADDR_W-1:0] l2_addr, sect_pa, large_pa, small_pa;

    ptw_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_world (cfg_ns),
        .wr_sel   (cfg_sel),
        .wr_data  (cfg_wdata),
        .rd_world (miss_ns),
        .rd_ctl   (ctl),
        .rd_base0 (base0),
        .rd_base1 (base1)
    );

    ptw_base_sel u_sel (
        .ctl     (ctl),
        .base0   (base0),
        .base1   (base1),
        .va_top  (miss_va[31:20]),
        .use_b1  (use_b1),
        .blocked (blocked),
        .l1_addr (l1_addr)
    );

    ptw_desc_dec u_dec (
        .desc     (mem_rdata),
        .va_low   (va_low_q),
        .l1_kind  (l1_kind),
        .l2_kind  (l2_kind),
        .l2_addr  (l2_addr),
        .sect_pa  (sect_pa),
        .large_pa (large_pa),
        .small_pa (small_pa)
    );

    assign accept     = miss_valid && (state_q == ST_IDLE);
    assign miss_ready = (state_q == ST_IDLE);
    assign mem_req    = (state_q != ST_IDLE);
    assign mem_addr   = addr_q;

    // Walk sequencing and registered result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            va_low_q <= '0;
            addr_q   <= '0;
            done     <= 1'b0;
            pa       <= '0;
            pg_size  <= SZ_NONE;
            fault    <= FLT_NONE;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: if (accept) begin
                    va_low_q <= miss_va[19:0];
                    if (blocked) begin
                        done    <= 1'b1;
                        pa      <= '0;
                        pg_size <= SZ_NONE;
                        fault   <= FLT_SECT;
                    end else begin
                        addr_q  <= l1_addr;
                        state_q <= ST_L1;
                    end
                end
                ST_L1: if (mem_ack) begin
                    case (l1_kind)
                        L1K_COARSE: begin
                            addr_q  <= l2_addr;
                            state_q <= ST_L2;
                        end
                        L1K_SECT: begin
                            done    <= 1'b1;
                            pa      <= sect_pa;
                            pg_size <= SZ_SECT;
                            fault   <= FLT_NONE;
                            state_q <= ST_IDLE;
                        end
                        default: begin
                            done    <= 1'b1;
                            pa      <= '0;
                            pg_size <= SZ_NONE;
                            fault   <= FLT_SECT;
                            state_q <= ST_IDLE;
                        end
                    endcase
                end
                ST_L2: if (mem_ack) begin
                    done    <= 1'b1;
                    state_q <= ST_IDLE;
                    case (l2_kind)
                        L2K_LARGE: begin
                            pa      <= large_pa;
                            pg_size <= SZ_LARGE;
                            fault   <= FLT_NONE;
                        end
                        L2K_SMALL: begin
                            pa      <= small_pa;
                            pg_size <= SZ_SMALL;
                            fault   <= FLT_NONE;
                        end
                        default: begin
                            pa      <= '0;
                            pg_size <= SZ_NONE;
                            fault   <= FLT_PAGE;
                        end
                    endcase
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ptw_checker.sv
// Module: temporal checks on the walker's ports, bound to every ptw_top.
module ptw_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        miss_valid,
    input logic        miss_ready,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        mem_ack,
    input logic        done,
    input logic [1:0]  pg_size,
    input logic [1:0]  fault
);
    // R11: a pending read holds its address until acknowledged
    p_req_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R11: no miss is taken while a read is outstanding
    p_busy_not_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !miss_ready);

    // R5: an accepted miss either starts a read or faults at once
    p_fast_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_ready) |=> (mem_req || (done && fault == 2'd1)));

    // R4: descriptor addresses are word aligned
    p_word_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R10: a result has a size exactly when it has no fault
    p_size_vs_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((fault == 2'd0) == (pg_size != 2'd0)));

    // R11: a walk that ended on a read acknowledge gives one done pulse
    p_single_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !$past(miss_valid && miss_ready)) |=> !done || $past(miss_valid));
endmodule

bind ptw_top ptw_checker u_ptw_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss_valid (miss_valid),
    .miss_ready (miss_ready),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .done       (done),
    .pg_size    (pg_size),
    .fault      (fault)
);

// File: tb/ptw_top_bench.sv
module ptw_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_ns = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic        miss_valid = 1'b0;
    logic        miss_ns = 1'b0;
    logic [31:0] miss_va = 32'd0;
    logic        miss_ready;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = 32'd0;
    logic        done;
    logic [31:0] pa;
    logic [1:0]  pg_size;
    logic [1:0]  fault;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // bench model of the configuration banks
    logic [31:0] m_ctl [2];
    logic [31:0] m_b0  [2];
    logic [31:0] m_b1  [2];

    always #5 clk = ~clk;

    ptw_top u_ptw_top (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ns(cfg_ns),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .miss_valid(miss_valid),
        .miss_ns(miss_ns), .miss_va(miss_va), .miss_ready(miss_ready),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .done(done), .pa(pa), .pg_size(pg_size),
        .fault(fault)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit pick_b1(input logic [31:0] ctl, input logic [31:0] va);
        int n = int'(ctl[2:0]);
        if (n == 0) return 1'b0;
        return (va >> (32 - n)) != 0;
    endfunction

    function automatic logic [31:0] exp_l1(input logic [31:0] ctl, input logic [31:0] b0,
                                           input logic [31:0] b1, input logic [31:0] va);
        int n = int'(ctl[2:0]);
        logic [31:0] idx;
        if (pick_b1(ctl, va)) return {b1[31:14], va[31:20], 2'b00};
        idx = {20'd0, va[31:20]} & ((32'd1 << (12 - n)) - 1);
        return ((b0 >> (14 - n)) << (14 - n)) | (idx << 2);
    endfunction

    task automatic cfg_write(input logic w, input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ns = w; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel == 2'd0) m_ctl[w] = d;
        else if (sel == 2'd1) m_b0[w] = d;
        else if (sel == 2'd2) m_b1[w] = d;
    endtask

    // One walk: poke_busy offers a second miss while busy (R11);
    // poke_cfg writes this world's control in the accept cycle (R12).
    task automatic walk(input logic [31:0] va, input logic ns, input logic [31:0] d1,
                        input logic [31:0] d2, input bit poke_busy, input bit poke_cfg,
                        input string tag);
        logic [31:0] ctl = m_ctl[ns];
        bit          b1 = pick_b1(ctl, va);
        bit          off = b1 ? ctl[5] : ctl[4];
        logic [31:0] a1 = exp_l1(ctl, m_b0[ns], m_b1[ns], va);
        logic [31:0] a2 = {d1[31:10], va[19:12], 2'b00};
        int          nreq_e = 0;
        logic [1:0]  f_e = 2'd0, s_e = 2'd0;
        logic [31:0] pa_e = 32'd0;
        int          stage = 0;
        int          lat = 0;
        bit          got = 0;
        if (off) begin
            f_e = 2'd1;
        end else if (d1[1:0] == 2'b10) begin
            nreq_e = 1; s_e = 2'd1; pa_e = {d1[31:20], va[19:0]};
        end else if (d1[1:0] == 2'b01) begin
            nreq_e = 2;
            if (d2[1:0] == 2'b00) f_e = 2'd2;
            else if (d2[1:0] == 2'b01) begin s_e = 2'd2; pa_e = {d2[31:16], va[15:0]}; end
            else begin s_e = 2'd3; pa_e = {d2[31:12], va[11:0]}; end
        end else begin
            nreq_e = 1; f_e = 2'd1;
        end
        @(negedge clk);
        chk(miss_ready == 1'b1, {tag, " R11 ready before miss"}, 32'(miss_ready), 32'd1);
        miss_valid = 1'b1; miss_va = va; miss_ns = ns;
        if (poke_cfg) begin
            cfg_we = 1'b1; cfg_ns = ns; cfg_sel = 2'd0; cfg_wdata = ctl | 32'h30;
        end
        @(negedge clk);
        cfg_we = 1'b0;
        if (poke_cfg) m_ctl[ns] = ctl | 32'h30;
        miss_valid = poke_busy; miss_va = ~va; miss_ns = ~ns;
        for (int i = 0; i < 60; i++) begin
            mem_ack = 1'b0;
            if (done) begin got = 1; miss_valid = 1'b0; break; end
            if (mem_req) begin
                chk(miss_ready == 1'b0, {tag, " R11 busy not ready"}, 32'(miss_ready), 32'd0);
                if (lat > 0) lat--;
                else begin
                    if (stage == 0)
                        chk(mem_addr == a1, {tag, " R3 R4 first-level address"}, mem_addr, a1);
                    else
                        chk(mem_addr == a2, {tag, " R8 second-level address"}, mem_addr, a2);
                    mem_rdata = (stage == 0) ? d1 : d2;
                    mem_ack = 1'b1;
                    stage++;
                    lat = int'($urandom_range(0, 3));
                end
            end
            @(negedge clk);
        end
        mem_ack = 1'b0;
        miss_valid = 1'b0;
        chk(got, {tag, " R11 done seen"}, 32'(got), 32'd1);
        chk(stage == nreq_e, {tag, " R5 R7 read count"}, 32'(stage), 32'(nreq_e));
        chk(fault == f_e, {tag, " R5 R7 R9 fault"}, 32'(fault), 32'(f_e));
        chk(pg_size == s_e, {tag, " R6 R10 size"}, 32'(pg_size), 32'(s_e));
        if (f_e == 2'd0) chk(pa == pa_e, {tag, " R6 R10 pa"}, pa, pa_e);
        @(negedge clk);
        chk(done == 1'b0, {tag, " R11 done one cycle"}, 32'(done), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int w = 0; w < 2; w++) begin m_ctl[w] = 0; m_b0[w] = 0; m_b1[w] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(miss_ready == 1'b1, "R1 ready after reset", 32'(miss_ready), 32'd1);
        chk(done == 1'b0, "R1 done after reset", 32'(done), 32'd0);
        chk(mem_req == 1'b0, "R1 no request after reset", 32'(mem_req), 32'd0);
        walk(32'hABC1_2345, 1'b1, 32'h1230_0002, 0, 0, 0, "R1 default regs");
        walk(32'hFFF0_0001, 1'b0, 32'h0000_0003, 0, 0, 0, "R1 R7 reserved type");
        // R3 / R4 base choice corners
        cfg_write(0, 2'd1, 32'h4567_89AB);
        cfg_write(0, 2'd2, 32'h89AB_CDEF);
        cfg_write(0, 2'd0, 32'd7);
        walk(32'h0200_0000, 0, 32'hFED0_0002, 0, 0, 0, "R3 split7 bit25 base1");
        walk(32'h01F0_0000, 0, 32'hFED0_0002, 0, 0, 0, "R3 split7 base0");
        cfg_write(0, 2'd0, 32'd3);
        walk(32'h1FF5_5555, 0, 32'h0000_0000, 0, 0, 0, "R4 R7 split3 base0 unmapped");
        walk(32'h2000_0000, 0, 32'h0000_0000, 0, 0, 0, "R3 split3 base1");
        // R2 banking and R5 disables
        cfg_write(1, 2'd0, 32'h30);
        walk(32'h1234_5678, 0, 32'h5550_0002, 0, 0, 0, "R2 other bank untouched");
        walk(32'h1234_5678, 1, 32'h5550_0002, 0, 0, 0, "R5 both disabled");
        cfg_write(1, 2'd0, 32'h21);
        walk(32'h8000_0000, 1, 32'h5550_0002, 0, 0, 0, "R5 off1 base1");
        walk(32'h7000_0000, 1, 32'h5550_0002, 0, 0, 0, "R5 off1 spares base0");
        cfg_write(1, 2'd0, 32'h11);
        walk(32'h7000_0000, 1, 32'h5550_0002, 0, 0, 0, "R5 off0 base0");
        cfg_write(1, 2'd3, 32'hFFFF_FFFF);
        walk(32'h8765_4321, 1, 32'h0000_0C01, 32'hAAAA_BBB1, 0, 0, "R2 sel3 R10 large");
        // R8-R10 second level
        walk(32'h0345_6789, 0, 32'hCAFE_F401, 32'h1357_9BDE, 0, 0, "R10 small");
        walk(32'h0345_6789, 0, 32'hCAFE_F401, 32'h1357_9BDC, 0, 0, "R9 page fault");
        walk(32'h0345_6789, 0, 32'hCAFE_F401, 32'h1357_9BDE, 1, 0, "R11 busy miss ignored");
        // R12 collision of write and accept
        walk(32'h0123_4567, 0, 32'hCAFE_F401, 32'h1357_9BDF, 0, 1, "R12 same-cycle write");
        walk(32'h0123_4567, 0, 32'hCAFE_F401, 32'h1357_9BDF, 0, 0, "R12 write now active");
        // random walks
        for (int k = 0; k < 300; k++) begin
            logic [31:0] d1, d2;
            if (k % 8 == 0) begin
                cfg_write(1'($urandom), 2'($urandom_range(0, 2)), $urandom);
                cfg_write(1'($urandom), 2'd0, $urandom & 32'h37 & ~32'h30 |
                          (($urandom_range(0, 3) == 0) ? ($urandom & 32'h30) : 32'h0));
            end
            d1 = $urandom;
            if ($urandom_range(0, 2) != 0) d1[1:0] = ($urandom_range(0, 1) == 0) ? 2'b01 : 2'b10;
            d2 = $urandom;
            walk($urandom, 1'($urandom), d1, d2, bit'($urandom_range(0, 1)),
                 ($urandom_range(0, 9) == 0), "R3 R4 R6 R10 random");
        end
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule